// File: doc/BRIEF.md
# Serial-Loaded Attenuation Control Register

This block holds the control word of a six-stage binary-weighted step attenuator. The stages are worth 16, 8, 4, 2, 1 and 0.5 dB. A word arrives one bit at a time on a serial data pin, qualified by a serial clock pin. The bits pass through a six-bit shift register. A level-controlled latch sits behind the shift register and decides when the word reaches the stage selects. While the latch-enable pin is high, the outputs follow the shift register. While it is low, they hold the value the shift register had when the pin fell.

The serial pins are plain control strobes with no valid/ready handshake, and nothing at this edge can apply back-pressure. A bit is accepted on every rising transition of the serial clock, whether the control logic is ready for it or not. The serial clock and the latch enable are sampled by the system clock, so each serial-clock phase must last at least one system clock period.

At power-up, which is modelled here as a synchronous reset, the shift register and the latch both load a six-bit preset from parallel pins. Any of the 64 settings can therefore be the starting state. At integration, the latch-enable input should be tied or pulled high when it has no driver. That way an undriven pin leaves the latch transparent.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `rst` is high at a `clk` edge, the shift register and the held value both load `preset`. After reset releases, `atten_sel` equals that preset whatever the level of `latch_en`.
- R2: At each `clk` edge where `ser_clk` is high and was low at the previous edge, `ser_data` enters bit 0 and the older bits move one place up. After six such edges, the first bit received sits in bit 5 (the 16 dB select) and the last bit received sits in bit 0 (the 0.5 dB select).
- R3: Shifting takes place while `latch_en` is low as well as while it is high. A word loaded with `latch_en` low appears on `atten_sel` as soon as `latch_en` is raised.
- R4: While `latch_en` is high, `atten_sel` equals the shift register contents and follows every shift.
- R5: While `latch_en` is low, `atten_sel` keeps the value the shift register had when `latch_en` fell, through any amount of further shifting.
- R6: When more than six bits are shifted, only the last six bits received before `latch_en` rises take effect.
- R7: `atten_half_db` is the total attenuation in 0.5 dB units: the sum of 32, 16, 8, 4, 2 and 1 for the set bits 5 down to 0 of `atten_sel`. It ranges from 0 to 63.
- R8: A `ser_clk` that stays high or stays low, and a falling edge of `ser_clk`, shift nothing, whatever `ser_data` does.
- R9: Raising `latch_en` after reset with no serial activity shows the preset on `atten_sel`, because the shift register also holds the preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. All sampling and state updates happen on its rising edge. |
| rst | input | 1 | Synchronous power-up reset, active high. Loads `preset`. |
| ser_clk | input | 1 | Serial clock. A bit is taken on each rising transition. |
| ser_data | input | 1 | Serial data, most significant bit first. |
| latch_en | input | 1 | Latch enable. High makes the latch transparent; low holds the value. |
| preset | input | 6 | Power-up setting. Bit 5 is the 16 dB select and bit 0 is the 0.5 dB select. |
| atten_sel | output | 6 | Stage selects. Bit 5 is 16 dB and bit 0 is 0.5 dB. |
| atten_half_db | output | 6 | Total attenuation in 0.5 dB units. |

## Verification
A word with a single leading one, checked after every bit with the latch open, shows whether bits travel upward and whether the first bit ends at the 16 dB stage. A single trailing one loaded with the latch closed separates a true hold from a latch that leaks shifts, and it also marks the 0.5 dB end. A nine-bit burst shows that only the final six bits count. Holding the serial clock high while the data toggles, and then letting it fall, separates edge capture from level capture. Two resets with different presets, including all ones and all zeros, cover both ends of the range of `atten_half_db`.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;
  // number of binary-weighted attenuation stages
  localparam int unsigned STAGES = 6;
endpackage

// File: rtl/sclk_rise_det.sv
module sclk_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  output logic rise
);
  logic sclk_q;

  // take the pin level during reset so a high serial clock is not seen as an edge
  always_ff @(posedge clk) begin
    sclk_q <= ser_clk;
  end

  assign rise = ser_clk & ~sclk_q & ~rst;

  // R8
  held_level_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_clk == sclk_q) |-> !rise);
endmodule

// File: rtl/atten_shreg.sv
module atten_shreg #(
  parameter int unsigned W = atten_ctrl_pkg::STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] preset,
  input  logic         shift_en,
  input  logic         ser_data,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  always_comb begin
    if (rst)           q_next = preset;
    else if (shift_en) q_next = {q[W-2:0], ser_data};
    else               q_next = q;
  end

  always_ff @(posedge clk) begin
    q <= q_next;
  end

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));
  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (q[0] == $past(ser_data)));
endmodule

// File: rtl/atten_hold.sv
module atten_hold #(
  parameter int unsigned W = atten_ctrl_pkg::STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] preset,
  input  logic         latch_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= preset;
    else if (latch_en) q <= load_val;
  end

  // R5
  hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(q));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int unsigned W = atten_ctrl_pkg::STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk,
  input  logic         ser_data,
  input  logic         latch_en,
  input  logic [W-1:0] preset,
  output logic [W-1:0] atten_sel,
  output logic [W-1:0] atten_half_db
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         rise;
  logic [W-1:0] sr_q;
  logic [W-1:0] sr_next;
  logic [W-1:0] hold_q;

  sclk_rise_det u_edge (
    .clk     (clk),
    .rst     (rst),
    .ser_clk (ser_clk),
    .rise    (rise)
  );

  atten_shreg #(.W(W)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .preset   (preset),
    .shift_en (rise),
    .ser_data (ser_data),
    .q        (sr_q),
    .q_next   (sr_next)
  );

  // the hold copy tracks the post-edge contents so a fall between edges captures them
  atten_hold #(.W(W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .preset   (preset),
    .latch_en (latch_en),
    .load_val (sr_next),
    .q        (hold_q)
  );

  // transparent while enabled, otherwise the captured word
  assign atten_sel = latch_en ? sr_q : hold_q;

  // weighted total: stage i is worth 2^i half-dB units
  logic [W-1:0] psum [W+1];
  assign psum[0] = '0;
  for (genvar i = 0; i < W; i++) begin : g_weight
    assign psum[i+1] = psum[i] + (atten_sel[i] ? (ONE << i) : '0);
  end
  assign atten_half_db = psum[W];

  // R1
  preset_load_chk: assert property (@(posedge clk)
    rst |=> (rst || atten_sel == $past(preset)));
  // R5
  out_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> (latch_en || $stable(atten_sel)));
  // R4
  transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_en && $past(latch_en) && !$past(rise)) |-> $stable(atten_sel));
  // R7
  half_db_chk: assert property (@(posedge clk) disable iff (rst)
    atten_half_db == atten_sel);
endmodule

// File: tb/tb_step_atten_ctrl.sv
module tb_step_atten_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       latch_en = 1'b0;
  logic [5:0] preset = 6'd0;
  logic [5:0] atten_sel;
  logic [5:0] atten_half_db;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  // reference model built from the requirements
  logic [5:0] ref_sr;
  logic [5:0] ref_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_atten_ctrl dut (
    .clk           (clk),
    .rst           (rst),
    .ser_clk       (ser_clk),
    .ser_data      (ser_data),
    .latch_en      (latch_en),
    .preset        (preset),
    .atten_sel     (atten_sel),
    .atten_half_db (atten_half_db)
  );

  // monitor: pops expectations and compares both outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      @(negedge clk);
      begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (atten_sel !== e) begin
          failures++;
          $display("FAIL %s atten_sel actual=%0d expected=%0d", t, atten_sel, e);
        end
        checks++;
        if (atten_half_db !== e) begin
          failures++;
          $display("FAIL %s/R7 atten_half_db actual=%0d expected=%0d", t, atten_half_db, e);
        end
      end
    end
  end

  function automatic logic [5:0] ref_out();
    return latch_en ? ref_sr : ref_hold;
  endfunction

  task automatic expect_now(input string tag);
    exp_q.push_back(ref_out());
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
  endtask

  task automatic do_reset(input logic [5:0] p);
    @(negedge clk);
    rst = 1'b1; preset = p; ser_clk = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ref_sr = p; ref_hold = p;
  endtask

  task automatic set_le(input logic v);
    @(negedge clk);
    latch_en = v;
    if (v) ref_hold = ref_sr;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_data = b; ser_clk = 1'b0;
    @(negedge clk); ser_clk = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
    ref_sr = {ref_sr[4:0], b};
    if (latch_en) ref_hold = ref_sr;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: preset with latch closed
    do_reset(6'b101101);
    expect_now("R1 preset 45");
    // R9: open latch without shifting shows preset
    set_le(1'b1);
    expect_now("R9 open after reset");
    // R4 and R2: leading one, checked after every bit
    send_bit(1'b1); expect_now("R4 bit1");
    for (int i = 0; i < 5; i++) begin
      send_bit(1'b0);
      expect_now("R4 follow");
    end
    expect_now("R2 first bit at 16dB");
    // R5: shift with latch closed, output holds 32
    set_le(1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    send_bit(1'b1);
    expect_now("R5 hold");
    // R3 and R2: shifted while closed, appears on opening, last bit at 0.5dB
    set_le(1'b1);
    expect_now("R3 R2 last bit at 0.5dB");
    // R6: nine bits, last six count
    set_le(1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    set_le(1'b1);
    expect_now("R6 last six");
    // R8: one rising edge, then held high with toggling data, then a fall
    @(negedge clk); ser_data = 1'b1;
    @(negedge clk); ser_clk = 1'b1;
    ref_sr = {ref_sr[4:0], 1'b1}; ref_hold = ref_sr;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ser_data = ~ser_data;
    end
    expect_now("R8 held high");
    @(negedge clk); ser_data = 1'b0; ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    expect_now("R8 falling edge");
    // R7: extremes of the range
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    expect_now("R7 all ones 63");
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    expect_now("R7 all zeros 0");
    // R1: reset with latch open to all ones
    do_reset(6'b111111);
    expect_now("R1 preset 63 open");
    // R5: latch closed mid-word
    send_bit(1'b0); send_bit(1'b1);
    set_le(1'b0);
    send_bit(1'b0); send_bit(1'b0);
    expect_now("R5 mid-word hold");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule